// File: doc/BRIEF.md
# Five-Lane Pixel Tap Serializer

This block turns pixel groups held in five parallel two-pixel FIFO lanes into one stream of 8-bit pixels, one pixel per output clock, for a line-scan camera output. Each lane is a show-ahead FIFO. Its head word is present on the data input whenever the lane is not empty, and a one-cycle read strobe removes it. Lane k (counted from 0) holds pixels 2k+1 and 2k+2 of every ten-pixel group.

A line starts in an idle state. When no lane is empty, one pre-read cycle fetches pixels 1 to 10 from all five lanes. The controller then walks a ten-step selection schedule through a two-level mux. The first level holds two muxes, one for the low bytes and one for the high bytes of the lanes, both driven by a 3-bit lane select. The second level picks one of those two muxes for the output tap. Each lane is fetched again as soon as its pair has been used up.

A line-valid flag travels with every lane-0 word. A group whose lane-0 flag is low marks the end of the line. None of its pixels is emitted, its remaining words are read away, and the controller goes back to idle. If a lane has not been refilled when the schedule reaches it, the stream stalls until that lane's data arrives.

Top module: `pixel_tap_serializer`

## Requirements
- R1: While reset is asserted and after its release, every read strobe is low and the output line-valid is low until a line starts.
- R2: In idle no lane is read until every lane reports not-empty. Then all five read strobes assert together for exactly one cycle, and the controller leaves idle.
- R3: Lane k's word carries pixel 2k+1 in bits [7:0] and pixel 2k+2 in bits [15:8]. The pixels of each group leave in the order 1, 2, 3 … 10, and groups leave in FIFO order.
- R4: The pixel output and the output line-valid are registered one clock after the selecting cycle. While no lane runs empty, a line of N groups gives exactly 10·N consecutive cycles with line-valid high.
- R5: Lane k's read strobe is high in the cycle in which its second pixel is visible on the output, unless that lane is empty.
- R6: A read strobe is never asserted while its lane reports empty.
- R7: When the lane the schedule needs has not been refilled, the output line-valid is low and the pixel output holds its value. No pixel is lost or repeated.
- R8: The line-valid flag is taken with each lane-0 word. A group whose lane-0 flag is 0 emits no pixel. The controller reads that group's words from the other lanes, returns to idle, and starts the next line with a new pre-read. This holds for a line of zero groups as well.
- R9: Outside a line (in idle and between lines) the output line-valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| laneData | input | 80 | Head words of the five lanes, lane k at bits [16k+15:16k] |
| laneEmpty | input | 5 | Per-lane empty flag |
| headLval | input | 1 | Line-valid flag of the lane-0 head word |
| laneRd | output | 5 | Per-lane read strobe, one word per high cycle |
| pixOut | output | 8 | Serialized pixel |
| lineValidOut | output | 1 | High in cycles where pixOut carries a line pixel |

## Verification
The bench builds the block with its defaults: five lanes and 8-bit pixels. This gives a ten-step schedule and a 3-bit select that never reaches its three spare codes. With these values every lane-to-byte position is checked on every group. The refill of lane 4 lands in the same cycle that the next group's first pixel leaves. Random per-lane empty masking places stalls at every schedule position, including the wrap from pixel 10 to pixel 1. Lines of zero, one and several groups cover the pre-read, the steady loop and the terminator drain.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
  parameter int LANES_P = 5;
  parameter int PIX_W_P = 8;
  parameter int SEL_W_P = $clog2(LANES_P);

  // strobes from the controller to the datapath, one set per cycle
  typedef struct packed {
    logic                emit;     // a pixel is selected this cycle
    logic                hiSel;    // second-level select: high-byte mux
    logic [SEL_W_P-1:0]  laneSel;  // first-level select: lane index
  } dpCtrl_t;
endpackage

// File: rtl/pixser_ctrl.sv
module pixser_ctrl
  import pixser_pkg::*;
#(
  parameter int LANES = LANES_P
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] laneEmpty,
  input  logic             headLval,
  output logic [LANES-1:0] laneRd,
  output dpCtrl_t          dpCtrl,
  output logic             inIdle
);
  localparam int POS_W = $clog2(2 * LANES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(2 * LANES - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;

  state_t             state;
  logic [LANES-1:0]   vld;
  logic [LANES-1:0]   clrMask;
  logic               lv0;
  logic [POS_W-1:0]   pos;
  logic [SEL_W_P-1:0] curLane;
  logic               allReady;
  logic               atGroupStart;
  logic               isEnd;
  logic               emit;

  always_comb begin
    allReady     = ~|laneEmpty;
    curLane      = SEL_W_P'(pos >> 1);
    atGroupStart = (pos == '0);
    isEnd        = (state == S_RUN) && atGroupStart && vld[0] && !lv0;
    emit         = (state == S_RUN) && vld[curLane] && !(atGroupStart && !lv0);
    clrMask      = '0;
    if (emit && pos[0]) clrMask[curLane] = 1'b1;
    if (state == S_IDLE) laneRd = allReady ? '1 : '0;
    else                 laneRd = ~vld & ~laneEmpty;
    dpCtrl.emit    = emit;
    dpCtrl.hiSel   = pos[0];
    dpCtrl.laneSel = curLane;
    inIdle         = (state == S_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      vld   <= '0;
      lv0   <= 1'b0;
      pos   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (allReady) begin
            state <= S_RUN;
            vld   <= '1;
            lv0   <= headLval;
            pos   <= '0;
          end
        end
        S_RUN: begin
          vld <= (vld | laneRd) & ~clrMask;
          if (laneRd[0]) lv0 <= headLval;
          if (emit) pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
          if (isEnd) state <= S_DRAIN;
        end
        default: begin
          if (&vld) begin
            state <= S_IDLE;
            vld   <= '0;
          end else begin
            vld <= vld | laneRd;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pixser_datapath.sv
module pixser_datapath
  import pixser_pkg::*;
#(
  parameter int LANES = LANES_P,
  parameter int PIX_W = PIX_W_P
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LANES*2*PIX_W-1:0] laneData,
  input  logic [LANES-1:0]         laneLoad,
  input  dpCtrl_t                  dpCtrl,
  output logic [PIX_W-1:0]         pixOut,
  output logic                     lineValidOut
);
  localparam int PAIR_W = 2 * PIX_W;

  logic [PAIR_W-1:0] pairReg [LANES];
  logic [PIX_W-1:0]  loMux;
  logic [PIX_W-1:0]  hiMux;
  logic [PIX_W-1:0]  tapMux;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           pairReg[k] <= '0;
      else if (laneLoad[k]) pairReg[k] <= laneData[k*PAIR_W +: PAIR_W];
    end
  end

  always_comb begin
    loMux  = pairReg[dpCtrl.laneSel][PIX_W-1:0];
    hiMux  = pairReg[dpCtrl.laneSel][PAIR_W-1:PIX_W];
    tapMux = dpCtrl.hiSel ? hiMux : loMux;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOut       <= '0;
      lineValidOut <= 1'b0;
    end else begin
      lineValidOut <= dpCtrl.emit;
      if (dpCtrl.emit) pixOut <= tapMux;
    end
  end
endmodule

// File: rtl/pixel_tap_serializer.sv
module pixel_tap_serializer
  import pixser_pkg::*;
#(
  parameter int LANES = LANES_P,
  parameter int PIX_W = PIX_W_P
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LANES*2*PIX_W-1:0] laneData,
  input  logic [LANES-1:0]         laneEmpty,
  input  logic                     headLval,
  output logic [LANES-1:0]         laneRd,
  output logic [PIX_W-1:0]         pixOut,
  output logic                     lineValidOut
);
  dpCtrl_t dpCtrl;
  logic    inIdle;

  pixser_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .laneEmpty(laneEmpty),
    .headLval (headLval),
    .laneRd   (laneRd),
    .dpCtrl   (dpCtrl),
    .inIdle   (inIdle)
  );

  pixser_datapath #(.LANES(LANES), .PIX_W(PIX_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .laneData    (laneData),
    .laneLoad    (laneRd),
    .dpCtrl      (dpCtrl),
    .pixOut      (pixOut),
    .lineValidOut(lineValidOut)
  );
endmodule

// File: rtl/pixser_chk.sv
module pixser_chk #(
  parameter int LANES = 5,
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [LANES-1:0] laneEmpty,
  input logic [LANES-1:0] laneRd,
  input logic [PIX_W-1:0] pixOut,
  input logic             lineValidOut,
  input logic             inIdle
);
  // R6
  no_read_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (laneRd & laneEmpty) == '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !lineValidOut);

  // R2
  idle_bulk_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inIdle && (|laneRd)) |-> (&laneRd));

  // R2
  idle_leave_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inIdle && (|laneRd)) |=> !inIdle);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    inIdle |=> !lineValidOut);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineValidOut |-> $stable(pixOut));
endmodule

bind pixel_tap_serializer pixser_chk #(.LANES(LANES), .PIX_W(PIX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .laneEmpty   (laneEmpty),
  .laneRd      (laneRd),
  .pixOut      (pixOut),
  .lineValidOut(lineValidOut),
  .inIdle      (inIdle)
);

// File: tb/pixel_tap_serializer_tb.sv
`timescale 1ns/1ps
module pixel_tap_serializer_tb;
  localparam int L = 5;

  logic           clk = 1'b0;
  logic           rstN;
  logic [L*16-1:0] laneData;
  logic [L-1:0]   laneEmpty;
  logic           headLval;
  logic [L-1:0]   laneRd;
  logic [7:0]     pixOut;
  logic           lineValidOut;

  always #4 clk = ~clk;

  pixel_tap_serializer u_dut (
    .clk(clk), .rstN(rstN), .laneData(laneData), .laneEmpty(laneEmpty),
    .headLval(headLval), .laneRd(laneRd), .pixOut(pixOut),
    .lineValidOut(lineValidOut)
  );

  logic [16:0] laneQ [L][$];
  logic [7:0]  expQ [$];
  int checks = 0, fails = 0;
  int cyc = 0, lineCount = 0, firstC = -1, lastC = -1, posInGrp = 0;
  int stallPct = 0;
  logic [L-1:0] forceMask = '0;
  bit done = 0;

  function automatic logic [7:0] pixVal(int ln, int idx);
    return 8'((ln * 53 + idx * 29 + 7) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushLine(int ln, int groups);
    for (int g = 0; g < groups; g++)
      for (int k = 0; k < L; k++) begin
        logic [7:0] lo = pixVal(ln, g*10 + 2*k);
        logic [7:0] hi = pixVal(ln, g*10 + 2*k + 1);
        laneQ[k].push_back({1'b1, hi, lo});
        expQ.push_back(lo);
        expQ.push_back(hi);
      end
    for (int k = 0; k < L; k++)
      laneQ[k].push_back({1'b0, 16'($urandom)});
  endtask

  // one clock: check outputs, drive inputs, then model the FIFO pops
  task automatic step();
    bit oddSeen = 0;
    int oddLane = 0;
    @(negedge clk);
    cyc++;
    if (lineValidOut) begin
      if (expQ.size() == 0) chk(0, "R8", "pixel outside a line", pixOut, -1);
      else begin
        logic [7:0] e = expQ.pop_front();
        chk(pixOut == e, "R3", "pixel value", pixOut, e);
      end
      lineCount++;
      if (firstC < 0) firstC = cyc;
      lastC = cyc;
      oddSeen = posInGrp[0];
      oddLane = posInGrp / 2;
      posInGrp = (posInGrp == 9) ? 0 : posInGrp + 1;
    end
    for (int k = 0; k < L; k++) begin
      bit m = ($urandom_range(99) < stallPct) || forceMask[k];
      laneEmpty[k] = (laneQ[k].size() == 0) || m;
      laneData[k*16 +: 16] = (laneQ[k].size() != 0) ? laneQ[k][0][15:0] : 16'h0;
    end
    headLval = (laneQ[0].size() != 0) ? laneQ[0][0][16] : 1'b0;
    #1;
    if (|laneRd) chk((laneRd & laneEmpty) == '0, "R6", "read while empty", laneRd, 0);
    if (oddSeen)
      chk(laneRd[oddLane] == !laneEmpty[oddLane], "R5", "refill strobe",
          laneRd[oddLane], !laneEmpty[oddLane]);
    for (int k = 0; k < L; k++)
      if (laneRd[k] && laneQ[k].size() != 0) void'(laneQ[k].pop_front());
  endtask

  task automatic drainLine(int groups, bit contig, string tag);
    int guard = 0;
    while (!((laneQ[0].size() == 0) && (laneQ[1].size() == 0) && (laneQ[2].size() == 0) &&
             (laneQ[3].size() == 0) && (laneQ[4].size() == 0) && expQ.size() == 0) &&
           guard < 3000) begin
      step();
      guard++;
    end
    repeat (4) begin
      step();
      chk(!lineValidOut, "R9", {tag, " valid after line"}, lineValidOut, 0);
    end
    chk(lineCount == 10 * groups, "R8", {tag, " pixel count"}, lineCount, 10 * groups);
    chk(expQ.size() == 0, "R7", {tag, " pixels left"}, expQ.size(), 0);
    if (contig && groups > 0)
      chk(lastC - firstC + 1 == 10 * groups, "R4", {tag, " contiguous span"},
          lastC - firstC + 1, 10 * groups);
  endtask

  task automatic startLine();
    lineCount = 0; firstC = -1; lastC = -1; posInGrp = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    laneEmpty = '1;
    laneData = '0;
    headLval = 1'b0;
    repeat (3) @(negedge clk);
    chk(laneRd == '0, "R1", "read strobes in reset", laneRd, 0);
    chk(!lineValidOut, "R1", "valid in reset", lineValidOut, 0);
    rstN = 1'b1;
    step();
    chk(laneRd == '0 && !lineValidOut, "R1", "quiet after reset", laneRd, 0);

    // R2: one lane held empty keeps the controller in idle
    startLine();
    pushLine(1, 1);
    forceMask = 5'b10000;
    repeat (5) begin
      step();
      chk(laneRd == '0, "R2", "read before all lanes ready", laneRd, 0);
    end
    forceMask = '0;
    step();
    chk(laneRd == 5'h1f, "R2", "bulk pre-read", laneRd, 5'h1f);
    drainLine(1, 1, "single group");

    // R4: multi-group line with no stalls
    startLine();
    pushLine(2, 3);
    drainLine(3, 1, "three groups");

    // R8: terminator-only line, then a normal line behind it
    startLine();
    pushLine(3, 0);
    drainLine(0, 0, "empty line");
    startLine();
    pushLine(4, 2);
    drainLine(2, 1, "after empty line");

    // R7: random stalls
    for (int i = 0; i < 8; i++) begin
      int gr = $urandom_range(1, 6);
      stallPct = $urandom_range(10, 40);
      startLine();
      pushLine(10 + i, gr);
      drainLine(gr, 0, "stalled line");
    end
    stallPct = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule